// File: doc/BRIEF.md
# Sprite Line Shifter with Early-Clock Start

This block turns up to four preloaded sprite slices into a per-pixel sprite colour stream for one scan line. During horizontal blank a loader writes each slot with a bit pattern (8 or 16 pixels wide), a horizontal byte and a tag byte. The tag byte carries a colour and an early-start flag. During the active line a pixel enable steps an internal column counter. Each slot waits for its start column, then emits one pattern bit per enabled pixel.

The early-start flag does not widen the horizontal byte. It moves the slot's start 32 pixel steps sooner, so the byte then covers columns -32 to 223, and a sprite can enter from the left edge partly visible. The four slots are merged by fixed priority into one colour with a valid bit. A sticky overlap flag is raised when two or more slots put out a 1 bit at the same visible column. Software clears the flag with a read strobe.

The load side is a valid/ready stream. Ready follows horizontal blank, so the loader is held back for the whole active line. The pixel output cannot be stalled, because it runs at the raster rate. Control and status pins are plain levels.

Top module: `spr_line_shifter`

## Requirements
- R1: `ld_ready` equals `hblank`. A slot is written only on a cycle where `ld_valid` and `ld_ready` are both high. A load offered during the active line changes nothing.
- R2: With `ld_tag[7]` = 0, the first pattern bit appears at the column equal to `ld_xpos` (0..255).
- R3: With `ld_tag[7]` = 1, the first pattern bit appears at column `ld_xpos` - 32. Bits that fall on columns below 0 are never shown.
- R4: With `ld_wide` = 1, all 16 bits of `ld_pattern` are emitted, bit 15 first. With `ld_wide` = 0, only `ld_pattern[7:0]` is emitted, bit 7 first.
- R5: A slot's colour is `ld_tag[3:0]`. Tag bits 6..4 have no effect.
- R6: Colour 0 is transparent. A slot drives the output only where its bit is 1 and its colour is non-zero. `spr_color` is 0 whenever `spr_valid` is 0.
- R7: When several slots drive the same column, the slot with the lowest `ld_slot` index sets `spr_color`.
- R8: `coll_flag` is set when two or more slots have a 1 bit at the same visible column, whatever their colours. It stays set until it is cleared.
- R9: A high `stat_rd` on a clock edge clears `coll_flag`.
- R10: A slot emits its bits once per line. A slot that is not loaded during a blank period emits nothing on the following line.
- R11: After reset, `spr_valid`, `spr_color` and `coll_flag` are 0.
- R12: The pixel for column c is computed on the edge with `pix_en` high at the (c+32)-th enabled step after blank ends, and holds from that edge until the next step. While `hblank` is high the output is cleared. Steps beyond column 255 show nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-domain clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hblank | input | 1 | High during horizontal blank; a falling edge starts a line |
| pix_en | input | 1 | One pulse per pixel step during the active line |
| ld_valid | input | 1 | Slot load offered |
| ld_ready | output | 1 | Load accepted when high together with ld_valid |
| ld_slot | input | 2 | Slot index to write |
| ld_pattern | input | 16 | Pattern bits, MSB first |
| ld_wide | input | 1 | 1 = 16-pixel pattern, 0 = 8-pixel pattern from the low byte |
| ld_xpos | input | 8 | Horizontal start byte |
| ld_tag | input | 8 | Bit 7 early start, bits 3:0 colour |
| stat_rd | input | 1 | Clears the overlap flag |
| spr_valid | output | 1 | A visible sprite pixel is present |
| spr_color | output | 4 | Colour of the winning slot |
| coll_flag | output | 1 | Sticky overlap status |

## Verification
The properties assume that `pix_en` pulses only while `hblank` is low, and that loads arrive only during blank. The bench drives exactly 288 enabled steps per line and raises blank right after the last one. It offers a single out-of-window load only to confirm that such a load is refused. `stat_rd` is pulsed only during blank. That keeps the clear-then-stays-clear property free of same-cycle collisions.

// File: rtl/spr_shift_pkg.sv
package spr_shift_pkg;
  localparam int NUM_SLOTS = 4;
  localparam int PAT_W     = 16;
  localparam int XPOS_W    = 8;
  localparam int COL_W     = 4;
  localparam int TAG_W     = 8;
  localparam int EARLY_OFS = 32;
  localparam int LINE_PIX  = 256;

  localparam int SLOT_W    = $clog2(NUM_SLOTS);
  localparam int NARROW_W  = PAT_W / 2;
  localparam int STEP_END  = LINE_PIX + EARLY_OFS;
  localparam int CNT_W     = $clog2(STEP_END + 1);
  localparam int REM_W     = $clog2(PAT_W + 1);
  localparam int EARLY_BIT = TAG_W - 1;

  typedef struct packed {
    logic [PAT_W-1:0] pattern;
    logic [REM_W-1:0] length;
    logic [CNT_W-1:0] start;
    logic [COL_W-1:0] color;
  } slot_load_t;
endpackage

// File: rtl/spr_step_counter.sv
module spr_step_counter
  import spr_shift_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hblank,
  input  logic             pix_en,
  output logic [CNT_W-1:0] cnt_o,
  output logic             step_o,
  output logic             vis_o,
  output logic             blank_rise_o
);
  localparam logic [CNT_W-1:0] END_CNT = CNT_W'(STEP_END);
  localparam logic [CNT_W-1:0] VIS_LO  = CNT_W'(EARLY_OFS);

  logic [CNT_W-1:0] cnt_q;
  logic             blank_q;

  assign step_o       = pix_en && !hblank;
  assign vis_o        = (cnt_q >= VIS_LO) && (cnt_q < END_CNT);
  assign blank_rise_o = hblank && !blank_q;
  assign cnt_o        = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      blank_q <= 1'b1;
    end else begin
      blank_q <= hblank;
      if (hblank) begin
        cnt_q <= '0;
      end else if (step_o && (cnt_q != END_CNT)) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/spr_slot.sv
module spr_slot
  import spr_shift_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             ld_i,
  input  slot_load_t       ld_data_i,
  input  logic             step_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             bit_o,
  output logic [COL_W-1:0] color_o
);
  logic [PAT_W-1:0] sr_q;
  logic [REM_W-1:0] rem_q;
  logic [CNT_W-1:0] start_q;
  logic [COL_W-1:0] color_q;
  logic             armed_q;
  logic             run_q;
  logic             hit;
  logic             busy;
  logic             active;

  assign hit     = armed_q && (cnt_i == start_q);
  assign busy    = run_q && (rem_q != '0);
  assign active  = hit || busy;
  assign bit_o   = active && sr_q[PAT_W-1];
  assign color_o = color_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr_q    <= '0;
      rem_q   <= '0;
      start_q <= '0;
      color_q <= '0;
      armed_q <= 1'b0;
      run_q   <= 1'b0;
    end else if (ld_i) begin
      sr_q    <= ld_data_i.pattern;
      rem_q   <= ld_data_i.length;
      start_q <= ld_data_i.start;
      color_q <= ld_data_i.color;
      armed_q <= 1'b1;
      run_q   <= 1'b0;
    end else if (clr_i) begin
      armed_q <= 1'b0;
      run_q   <= 1'b0;
      rem_q   <= '0;
    end else if (step_i && active) begin
      sr_q  <= {sr_q[PAT_W-2:0], 1'b0};
      rem_q <= rem_q - 1'b1;
      if (hit) begin
        armed_q <= 1'b0;
        run_q   <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/spr_merge.sv
module spr_merge
  import spr_shift_pkg::*;
(
  input  logic [NUM_SLOTS-1:0]            bits_i,
  input  logic [NUM_SLOTS-1:0][COL_W-1:0] colors_i,
  output logic                            any_o,
  output logic [COL_W-1:0]                color_o,
  output logic                            multi_o
);
  logic [NUM_SLOTS-1:0] opaque;
  logic [SLOT_W:0]      ones;

  genvar g;
  generate
    for (g = 0; g < NUM_SLOTS; g++) begin : g_opq
      assign opaque[g] = bits_i[g] && (colors_i[g] != '0);
    end
  endgenerate

  always_comb begin
    color_o = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (opaque[i]) color_o = colors_i[i];
    end
  end

  always_comb begin
    ones = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      ones = ones + {{SLOT_W{1'b0}}, bits_i[i]};
    end
  end

  assign any_o   = |opaque;
  assign multi_o = ones >= (SLOT_W+1)'(2);
endmodule

// File: rtl/spr_line_shifter.sv
module spr_line_shifter
  import spr_shift_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hblank,
  input  logic              pix_en,
  input  logic              ld_valid,
  output logic              ld_ready,
  input  logic [SLOT_W-1:0] ld_slot,
  input  logic [PAT_W-1:0]  ld_pattern,
  input  logic              ld_wide,
  input  logic [XPOS_W-1:0] ld_xpos,
  input  logic [TAG_W-1:0]  ld_tag,
  input  logic              stat_rd,
  output logic              spr_valid,
  output logic [COL_W-1:0]  spr_color,
  output logic              coll_flag
);
  logic [CNT_W-1:0]            cnt;
  logic                        step;
  logic                        vis;
  logic                        blank_rise;
  logic                        ld_fire;
  slot_load_t                  ld_data;
  logic [NUM_SLOTS-1:0]        bits;
  logic [NUM_SLOTS-1:0][COL_W-1:0] colors;
  logic                        any_px;
  logic [COL_W-1:0]            win_color;
  logic                        multi;
  logic [CNT_W-1:0]            x_ext;

  assign ld_ready = hblank;
  assign ld_fire  = ld_valid && ld_ready;
  assign x_ext    = {{(CNT_W-XPOS_W){1'b0}}, ld_xpos};

  always_comb begin
    ld_data.pattern = ld_wide ? ld_pattern
                              : {ld_pattern[NARROW_W-1:0], {NARROW_W{1'b0}}};
    ld_data.length  = ld_wide ? REM_W'(PAT_W) : REM_W'(NARROW_W);
    ld_data.start   = ld_tag[EARLY_BIT] ? x_ext : x_ext + CNT_W'(EARLY_OFS);
    ld_data.color   = ld_tag[COL_W-1:0];
  end

  spr_step_counter u_cnt (
    .clk          (clk),
    .rst_n        (rst_n),
    .hblank       (hblank),
    .pix_en       (pix_en),
    .cnt_o        (cnt),
    .step_o       (step),
    .vis_o        (vis),
    .blank_rise_o (blank_rise)
  );

  genvar s;
  generate
    for (s = 0; s < NUM_SLOTS; s++) begin : g_slot
      spr_slot u_slot (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (blank_rise),
        .ld_i      (ld_fire && (ld_slot == SLOT_W'(s))),
        .ld_data_i (ld_data),
        .step_i    (step),
        .cnt_i     (cnt),
        .bit_o     (bits[s]),
        .color_o   (colors[s])
      );
    end
  endgenerate

  spr_merge u_merge (
    .bits_i   (bits),
    .colors_i (colors),
    .any_o    (any_px),
    .color_o  (win_color),
    .multi_o  (multi)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      spr_valid <= 1'b0;
      spr_color <= '0;
    end else if (hblank) begin
      spr_valid <= 1'b0;
      spr_color <= '0;
    end else if (step) begin
      spr_valid <= vis && any_px;
      spr_color <= (vis && any_px) ? win_color : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      coll_flag <= 1'b0;
    end else if (step && vis && multi) begin
      coll_flag <= 1'b1;
    end else if (stat_rd) begin
      coll_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/spr_line_shifter_chk.sv
module spr_line_shifter_chk
  import spr_shift_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             hblank,
  input logic             pix_en,
  input logic             stat_rd,
  input logic             spr_valid,
  input logic [COL_W-1:0] spr_color,
  input logic             coll_flag
);
  assert_opaque_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    spr_valid |-> (spr_color != '0));

  assert_idle_color_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !spr_valid |-> (spr_color == '0));

  assert_blank_clears_R12: assert property (@(posedge clk) disable iff (!rst_n)
    hblank |=> !spr_valid);

  assert_hold_between_steps_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!pix_en && !hblank) |=> ($stable(spr_valid) && $stable(spr_color)));

  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (coll_flag && !stat_rd) |=> coll_flag);

  assert_read_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && hblank) |=> !coll_flag);
endmodule

bind spr_line_shifter spr_line_shifter_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .hblank    (hblank),
  .pix_en    (pix_en),
  .stat_rd   (stat_rd),
  .spr_valid (spr_valid),
  .spr_color (spr_color),
  .coll_flag (coll_flag)
);

// File: tb/spr_line_shifter_tb.sv
module spr_line_shifter_tb;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hblank = 1'b1;
  logic        pix_en = 1'b0;
  logic        ld_valid = 1'b0;
  logic        ld_ready;
  logic [1:0]  ld_slot = '0;
  logic [15:0] ld_pattern = '0;
  logic        ld_wide = 1'b0;
  logic [7:0]  ld_xpos = '0;
  logic [7:0]  ld_tag = '0;
  logic        stat_rd = 1'b0;
  logic        spr_valid;
  logic [3:0]  spr_color;
  logic        coll_flag;

  int checks = 0;
  int fails  = 0;

  typedef struct { logic v; logic [3:0] c; int col; string req; } exp_t;
  exp_t q[$];
  logic mon_en = 1'b0;
  bit   done = 1'b0;

  logic        b_ld  [4];
  logic [15:0] b_pat [4];
  logic        b_wide[4];
  int          b_x   [4];
  logic [7:0]  b_tag [4];
  string       line_req = "R2";

  spr_line_shifter u_dut (
    .clk(clk), .rst_n(rst_n), .hblank(hblank), .pix_en(pix_en),
    .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_slot(ld_slot),
    .ld_pattern(ld_pattern), .ld_wide(ld_wide), .ld_xpos(ld_xpos),
    .ld_tag(ld_tag), .stat_rd(stat_rd), .spr_valid(spr_valid),
    .spr_color(spr_color), .coll_flag(coll_flag)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // bench model of one step index k (column k-32)
  task automatic model(input int k, output logic v, output logic [3:0] c, output int nb);
    v = 1'b0; c = '0; nb = 0;
    for (int i = 3; i >= 0; i--) begin
      if (b_ld[i]) begin
        int st, len, off;
        logic bt;
        st  = b_tag[i][7] ? b_x[i] : b_x[i] + 32;
        len = b_wide[i] ? 16 : 8;
        off = k - st;
        bt  = 1'b0;
        if (off >= 0 && off < len)
          bt = b_wide[i] ? b_pat[i][15-off] : b_pat[i][7-off];
        if (bt) begin
          nb++;
          if (b_tag[i][3:0] != 4'd0) begin
            v = 1'b1;
            c = b_tag[i][3:0];
          end
        end
      end
    end
  endtask

  task automatic load(input int s, input logic [15:0] p, input logic w, input int x, input logic [7:0] t);
    ld_valid = 1'b1; ld_slot = 2'(s); ld_pattern = p; ld_wide = w;
    ld_xpos = 8'(x); ld_tag = t;
    @(posedge clk); #1;
    ld_valid = 1'b0;
    b_ld[s] = 1'b1; b_pat[s] = p; b_wide[s] = w; b_x[s] = x; b_tag[s] = t;
  endtask

  // driver: pushes expected pixels, then steps one line of 288 pixels
  task automatic run_line(input bit bad_load);
    logic v; logic [3:0] c; int nb;
    bit exp_coll;
    exp_coll = 1'b0;
    for (int k = 32; k < 288; k++) begin
      exp_t e;
      model(k, v, c, nb);
      if (nb >= 2) exp_coll = 1'b1;
      e.v = v; e.c = c; e.col = k - 32; e.req = line_req;
      q.push_back(e);
    end
    hblank = 1'b0; pix_en = 1'b1;
    for (int k = 0; k < 288; k++) begin
      @(posedge clk); #1;
      mon_en = (k >= 32);
      if (bad_load && k == 100) begin
        check("R1", int'(ld_ready), 0, "ready during active line");
        ld_valid = 1'b1; ld_slot = 2'd0; ld_pattern = 16'hFFFF; ld_wide = 1'b1;
        ld_xpos = 8'd150; ld_tag = 8'h0E;
      end else begin
        ld_valid = 1'b0;
      end
      if (k == 287) begin
        hblank = 1'b1; pix_en = 1'b0;
      end
    end
    @(posedge clk); #1;
    mon_en = 1'b0;
    check("R12", int'(spr_valid), 0, "output cleared in blank");
    check("R12", q.size(), 0, "all visible pixels observed");
    check("R8", int'(coll_flag), int'(exp_coll), "overlap flag after line");
    stat_rd = 1'b1;
    @(posedge clk); #1;
    stat_rd = 1'b0;
    check("R9", int'(coll_flag), 0, "flag after status read");
    for (int i = 0; i < 4; i++) b_ld[i] = 1'b0;
  endtask

  // monitor: pops expected items and compares mid-cycle
  always @(negedge clk) begin
    if (mon_en) begin
      if (q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R12 unexpected pixel: actual output with empty queue expected none");
      end else begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (spr_valid !== e.v || spr_color !== e.c) begin
          fails++;
          $display("FAIL %s column %0d: actual v=%0b c=%0d expected v=%0b c=%0d",
                   e.req, e.col, spr_valid, spr_color, e.v, e.c);
        end
      end
    end
  end

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) b_ld[i] = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    // R11 reset state
    check("R11", int'(spr_valid), 0, "valid after reset");
    check("R11", int'(spr_color), 0, "colour after reset");
    check("R11", int'(coll_flag), 0, "flag after reset");
    check("R1", int'(ld_ready), 1, "ready during blank");

    // R2 R4 R5: narrow pattern from low byte, tag junk bits ignored
    line_req = "R2_R4_R5";
    load(0, 16'hFFA5, 1'b0, 10, 8'h75);
    run_line(1'b0);

    // R3 early start from left edge, R12 right edge cut off
    line_req = "R3_R12";
    load(1, 16'hFFFF, 1'b1, 24, 8'h83);
    load(2, 16'hF0F0, 1'b1, 250, 8'h09);
    load(3, 16'hC3C3, 1'b0, 250, 8'h0A);
    run_line(1'b0);

    // R6 transparency, R7 priority, R8 overlap regardless of colour
    line_req = "R6_R7_R8";
    load(0, 16'h00FF, 1'b0, 40, 8'h00);
    load(1, 16'h00FF, 1'b0, 40, 8'h06);
    load(3, 16'hFFFF, 1'b1, 76, 8'h8C);
    load(2, 16'h5555, 1'b1, 80, 8'h87);
    run_line(1'b0);

    // R10 nothing reloaded; R1 load offered mid-line refused
    line_req = "R1_R10";
    run_line(1'b1);
    line_req = "R1_R10";
    run_line(1'b0);

    // R3 fully hidden sprites overlapping off screen: no flag (R8); R2 column 255
    line_req = "R3_R8";
    load(0, 16'hFFFF, 1'b1, 0, 8'h81);
    load(2, 16'hFFFF, 1'b1, 8, 8'h82);
    load(1, 16'h0080, 1'b0, 255, 8'h04);
    run_line(1'b0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule